// File: doc/BRIEF.md
# Hibernate and Wake Controller

This block keeps a board in a low-power hibernate state once software asks for it. It then lets the board go when one of the wake sources that software has enabled becomes active. Software reaches it through one control register. Each write either sets or clears the bits named in the write data, and a select input picks which of the two the write does.

Four wake inputs arrive from other clock domains: a touch controller event, an external power-controller wake line, a shared interrupt pin, and a reset request. The interrupt pin can wake the board on its high level, its low level, or both. Each polarity has its own enable bit.

A wake clears the hibernate request bit and drops the hibernate output. It also raises a wake pulse for exactly one clock. The enable bits stay as they were, so the next hibernate needs only the request bit.

Top module: `hib_wake_ctrl`

## Requirements
- R1: After reset the register reads 0x00, `hibernate_o` is low and `wake_o` is low.
- R2: A write with `wr_clr`=0 ORs `wr_data[5:0]` into the register. Bits 7:6 always read 0.
- R3: A write with `wr_clr`=1 clears every register bit whose `wr_data` bit is 1 and leaves the other bits unchanged.
- R4: `hibernate_o` follows register bit 0 (hibernate request).
- R5: Each wake input passes through two synchronizing flops. A change that is stable before rising edge k takes effect on the register and outputs at rising edge k+2.
- R6: Register bit 1 enables waking on a high `touch_i`.
- R7: Register bit 2 enables waking on a high `pmic_wake_i`.
- R8: Register bit 3 enables waking on `irq_i` high, and register bit 5 enables waking on `irq_i` low.
- R9: Register bit 4 enables waking on a high `rst_req_i`.
- R10: When bit 0 is set and an enabled source is active, the next edge clears bit 0 and raises `wake_o` for one cycle. Bits 5:1 are kept.
- R11: While bit 0 is clear, wake inputs have no effect: `wake_o` stays low and the register is unchanged.
- R12: If a write and a wake coincide, the write is applied first and bit 0 is then forced to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_clr | input | 1 | Write mode: 0 sets bits, 1 clears bits |
| wr_data | input | 8 | Bit mask for the write |
| touch_i | input | 1 | Touch event, asynchronous |
| pmic_wake_i | input | 1 | External power-controller wake, asynchronous |
| irq_i | input | 1 | Shared interrupt pin level, asynchronous |
| rst_req_i | input | 1 | Reset request, asynchronous |
| reg_o | output | 8 | Current register contents |
| hibernate_o | output | 1 | High while hibernating |
| wake_o | output | 1 | One-cycle pulse on a wake |

## Verification
The assertions assume that `wr_en`, `wr_clr` and `wr_data` are synchronous to `clk` and free of unknowns once reset is released. The wake inputs may change at any time, because only their synchronized copies are evaluated.

The stimulus drives every input on the falling clock edge. Writes come in random bursts mixed with holds, and the wake levels are toggled rarely, so that each level lasts across the two synchronizer stages. Directed cases cover each wake source alone, both interrupt polarities, sources active while awake, and a write landing in the same cycle as a wake.

// File: rtl/hib_wake_pkg.sv
// Shared constants for the hibernate/wake controller.
// Assumes an 8-bit register with six implemented bits.
package hib_wake_pkg;
    localparam int REG_W    = 8;
    localparam int NUM_IN   = 4;
    localparam int SYNC_LEN = 2;

    // register bit positions (software-visible, fixed)
    localparam int B_HIB    = 0;
    localparam int B_TOUCH  = 1;
    localparam int B_PMIC   = 2;
    localparam int B_IRQHI  = 3;
    localparam int B_RSTRQ  = 4;
    localparam int B_IRQLO  = 5;
    localparam int IMPL_BITS = 6;

    // raw input vector positions
    localparam int I_TOUCH = 0;
    localparam int I_PMIC  = 1;
    localparam int I_IRQ   = 2;
    localparam int I_RSTRQ = 3;

    localparam logic [REG_W-1:0] IMPL_MASK = REG_W'((1 << IMPL_BITS) - 1);
endpackage

// File: rtl/hib_sync.sv
// Multi-stage flop synchronizer, one independent chain per bit.
// Assumes each bit is a level signal that stays stable for several clocks.
module hib_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        // shift the raw level through the chain
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], d_i[b]};
        end
        assign q_o[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/hib_wake_eval.sv
// Maps synchronized inputs onto the enable bits and decides whether a wake fires.
// Purely combinational; assumes synchronized inputs.
module hib_wake_eval
    import hib_wake_pkg::*;
(
    input  logic [REG_W-1:0]  reg_i,
    input  logic [NUM_IN-1:0] sync_i,
    output logic              fire_o
);
    logic [IMPL_BITS-1:0] src;

    // build the source vector in register bit order
    always_comb begin
        src          = '0;
        src[B_TOUCH] = sync_i[I_TOUCH];
        src[B_PMIC]  = sync_i[I_PMIC];
        src[B_IRQHI] = sync_i[I_IRQ];
        src[B_RSTRQ] = sync_i[I_RSTRQ];
        src[B_IRQLO] = ~sync_i[I_IRQ];
    end

    // wake only while hibernating and an enabled source is active
    always_comb begin
        fire_o = reg_i[B_HIB] & (|(reg_i[IMPL_BITS-1:1] & src[IMPL_BITS-1:1]));
    end
endmodule

// File: rtl/hib_ctrl_reg.sv
// Set/clear control register and the wake pulse flop.
// Assumes write inputs are synchronous; a wake has the last word on bit 0.
module hib_ctrl_reg
    import hib_wake_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_clr,
    input  logic [REG_W-1:0] wr_data,
    input  logic             fire_i,
    output logic [REG_W-1:0] reg_o,
    output logic             wake_o
);
    logic [REG_W-1:0] reg_q, reg_d, mask;

    // next value: write first, then a wake clears the request bit
    always_comb begin
        mask  = wr_data & IMPL_MASK;
        reg_d = reg_q;
        if (wr_en) reg_d = wr_clr ? (reg_q & ~mask) : (reg_q | mask);
        if (fire_i) reg_d[B_HIB] = 1'b0;
    end

    // register and pulse state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_q  <= '0;
            wake_o <= 1'b0;
        end else begin
            reg_q  <= reg_d;
            wake_o <= fire_i;
        end
    end

    assign reg_o = reg_q;
endmodule

// File: rtl/hib_wake_ctrl.sv
// Top level of the hibernate/wake controller.
// Assumes a single clock; wake inputs may be asynchronous to it.
module hib_wake_ctrl
    import hib_wake_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_clr,
    input  logic [REG_W-1:0] wr_data,
    input  logic             touch_i,
    input  logic             pmic_wake_i,
    input  logic             irq_i,
    input  logic             rst_req_i,
    output logic [REG_W-1:0] reg_o,
    output logic             hibernate_o,
    output logic             wake_o
);
    logic [NUM_IN-1:0] raw, synced;
    logic              fire;

    // gather raw inputs in package order
    always_comb begin
        raw          = '0;
        raw[I_TOUCH] = touch_i;
        raw[I_PMIC]  = pmic_wake_i;
        raw[I_IRQ]   = irq_i;
        raw[I_RSTRQ] = rst_req_i;
    end

    hib_sync #(.WIDTH(NUM_IN), .STAGES(SYNC_LEN)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(raw), .q_o(synced)
    );

    hib_wake_eval u_eval (
        .reg_i(reg_o), .sync_i(synced), .fire_o(fire)
    );

    hib_ctrl_reg u_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_clr(wr_clr),
        .wr_data(wr_data), .fire_i(fire), .reg_o(reg_o), .wake_o(wake_o)
    );

    assign hibernate_o = reg_o[B_HIB];
endmodule

// File: rtl/hib_wake_chk.sv
// Property checker for the hibernate/wake controller, bound to the top.
module hib_wake_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       wr_clr,
    input logic [7:0] wr_data,
    input logic [7:0] reg_o,
    input logic       hibernate_o,
    input logic       wake_o
);
    // R2
    unused_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_o[7:6] == 2'b00);
    // R2
    set_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_clr) |=> ((reg_o[5:1] & $past(wr_data[5:1])) == $past(wr_data[5:1])));
    // R3
    clear_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_clr) |=> ((reg_o[5:0] & $past(wr_data[5:0])) == 6'd0));
    // R10
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |=> !wake_o);
    // R10
    wake_drops_hib_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> !hibernate_o);
    // R10
    enables_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_o && !$past(wr_en)) |-> (reg_o[5:1] == $past(reg_o[5:1])));
    // R11
    no_wake_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(hibernate_o) |-> !wake_o);
endmodule

bind hib_wake_ctrl hib_wake_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_clr(wr_clr), .wr_data(wr_data),
    .reg_o(reg_o), .hibernate_o(hibernate_o), .wake_o(wake_o)
);

// File: tb/tb_hib_wake_ctrl.sv
module tb_hib_wake_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, wr_clr = 1'b0;
    logic [7:0] wr_data = '0;
    logic       touch_i = 1'b0, pmic_wake_i = 1'b0, irq_i = 1'b0, rst_req_i = 1'b0;
    logic [7:0] reg_o;
    logic       hibernate_o, wake_o;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    // bench model of the requirements
    logic [7:0] m_reg = '0;
    logic [3:0] m_s1 = '0, m_s2 = '0;
    logic       m_pulse = 1'b0;

    always #5 clk = ~clk;

    hib_wake_ctrl dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_clr(wr_clr), .wr_data(wr_data),
        .touch_i(touch_i), .pmic_wake_i(pmic_wake_i), .irq_i(irq_i), .rst_req_i(rst_req_i),
        .reg_o(reg_o), .hibernate_o(hibernate_o), .wake_o(wake_o)
    );

    function automatic logic model_fire(logic [7:0] r, logic [3:0] s);
        return r[0] && ((r[1] && s[0]) || (r[2] && s[1]) || (r[3] && s[2]) ||
                        (r[4] && s[3]) || (r[5] && !s[2]));
    endfunction

    function automatic logic [7:0] model_write(logic [7:0] r, logic en, logic clr, logic [7:0] d);
        logic [7:0] m = d & 8'h3F;
        if (!en) return r;
        return clr ? (r & ~m) : (r | m);
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one clock: inputs already driven at negedge; update model, compare at next negedge
    task automatic step(string tag);
        logic f;
        @(posedge clk);
        f = model_fire(m_reg, m_s2);
        m_reg = model_write(m_reg, wr_en, wr_clr, wr_data);
        if (f) m_reg[0] = 1'b0;
        m_pulse = f;
        m_s2 = m_s1;
        m_s1 = {rst_req_i, irq_i, pmic_wake_i, touch_i};
        @(negedge clk);
        check(tag, reg_o, m_reg);
        check("R4", {7'd0, hibernate_o}, {7'd0, m_reg[0]});
        check("R10", {7'd0, wake_o}, {7'd0, m_pulse});
        wr_en = 1'b0;
    endtask

    task automatic wr(logic clr, logic [7:0] d, string tag);
        wr_en = 1'b1; wr_clr = clr; wr_data = d;
        step(tag);
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    initial begin
        void'($urandom(32'd4711));
        irq_i = 1'b1;
        repeat (3) @(negedge clk);
        m_s1 = 4'b0; m_s2 = 4'b0;
        rst_n = 1'b1;
        // R1 reset state
        check("R1", reg_o, 8'h00);
        check("R1", {6'd0, hibernate_o, wake_o}, 8'h00);
        idle(3, "R1");

        // R2 set writes, upper bits stay zero
        wr(1'b0, 8'hC6, "R2");
        check("R2", reg_o, 8'h06);
        // R3 clear write
        wr(1'b1, 8'h04, "R3");
        check("R3", reg_o, 8'h02);

        // R6 touch wake with R5 latency
        wr(1'b0, 8'h01, "R4");
        touch_i = 1'b1;
        step("R5"); step("R5");
        check("R5", {7'd0, hibernate_o}, 8'h01);
        step("R6");
        check("R6", {7'd0, wake_o}, 8'h01);
        check("R10", reg_o, 8'h02);
        step("R10");
        touch_i = 1'b0; idle(3, "R6");

        // R11 sources active while awake
        pmic_wake_i = 1'b1; irq_i = 1'b0; rst_req_i = 1'b1;
        wr(1'b0, 8'h3C, "R11");
        idle(4, "R11");
        check("R11", reg_o, 8'h3E);
        pmic_wake_i = 1'b0; irq_i = 1'b1; rst_req_i = 1'b0;
        wr(1'b1, 8'h3F, "R3");
        idle(3, "R11");

        // R7 pmic wake
        wr(1'b0, 8'h04, "R7"); wr(1'b0, 8'h01, "R7");
        pmic_wake_i = 1'b1; idle(3, "R7");
        check("R7", reg_o, 8'h04);
        pmic_wake_i = 1'b0; wr(1'b1, 8'hFF, "R3"); idle(3, "R7");

        // R8 irq high then low
        wr(1'b0, 8'h09, "R8");
        idle(3, "R8");
        check("R8", reg_o, 8'h08);
        wr(1'b1, 8'h08, "R8");
        irq_i = 1'b0; idle(3, "R8");
        wr(1'b0, 8'h21, "R8");
        step("R8");
        check("R8", {7'd0, wake_o}, 8'h01);
        irq_i = 1'b1; wr(1'b1, 8'hFF, "R3"); idle(3, "R8");

        // R9 reset request wake
        wr(1'b0, 8'h11, "R9");
        rst_req_i = 1'b1; idle(3, "R9");
        check("R9", reg_o, 8'h10);
        rst_req_i = 1'b0; idle(3, "R9");

        // R12 write coinciding with a wake
        wr(1'b0, 8'h03, "R12");
        touch_i = 1'b1; step("R12"); step("R12");
        wr(1'b0, 8'h20, "R12");
        check("R12", reg_o, 8'h32);
        check("R12", {7'd0, wake_o}, 8'h01);
        touch_i = 1'b0; idle(3, "R12");

        // R2 random mix
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 3) == 0) begin
                wr_en = 1'b1; wr_clr = $urandom_range(0, 1) == 1;
                wr_data = 8'($urandom());
                if ($urandom_range(0, 2) == 0) begin wr_clr = 1'b0; wr_data[0] = 1'b1; end
            end
            if ($urandom_range(0, 15) == 0) touch_i = ~touch_i;
            if ($urandom_range(0, 15) == 0) pmic_wake_i = ~pmic_wake_i;
            if ($urandom_range(0, 15) == 0) irq_i = ~irq_i;
            if ($urandom_range(0, 15) == 0) rst_req_i = ~rst_req_i;
            step("R2");
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(100000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule